// File: doc/BRIEF.md
# Serial Configuration Loader

This block loads a configuration image into a programmable target device over a one-bit serial link with a separate serial clock. A host raises `start` for one cycle, then supplies the image as bytes on a valid/ready stream, with `s_last` marking the final byte. The loader first switches on the target's supply through an active-low power-off line. It then holds the target's configuration-reset line low for a fixed interval measured in system clocks, and releases it. After that it shifts each byte out one bit per serial clock, least significant bit first. Once the last byte has gone out it issues a fixed run of extra serial clocks with the data line at zero, and then reads the target's two status inputs.

The serial clock is derived from the system clock. `half_div` sets each half period to `half_div + 1` system clocks and is captured when the load starts. The data line only moves while the serial clock is low, so the target always samples a settled value on the rising edge. The two status inputs pass through a two-stage synchronizer. After the trailing clocks, `done` pulses if both read high and `error` pulses otherwise. The raw pair stays visible on `tgt_status` until the next check.

The controller is one state machine with these states: IDLE (waiting for `start`), RESET (configuration-reset held low), WAIT (ready for a byte), SHIFT (serializing a byte), TRAIL (extra clocks) and CHECK (status evaluation). Its transitions are: IDLE to RESET on `start`; RESET to WAIT when the reset interval ends; WAIT to SHIFT on a stream handshake; SHIFT back to WAIT after the eighth falling edge of a byte that is not the last; SHIFT to TRAIL after the eighth falling edge of the last byte; TRAIL to CHECK after the final trailing falling edge; and CHECK to IDLE unconditionally.

Top module: `pscfg_loader`

## Requirements
- R1: While reset is applied and directly after it: `pwr_off`=1, `cfg_rst_n`=1, `ser_clk`=0, `ser_data`=0, `busy`=0, `s_ready`=0, `done`=0, `error`=0.
- R2: A `start` accepted in IDLE drives `pwr_off` low on the next edge, and it stays low for the whole load.
- R3: `cfg_rst_n` is low for exactly RESET_US × CLK_HZ / 1e6 system clocks after start. It is high again before any byte is accepted.
- R4: Each byte is sent as 8 rising edges of `ser_clk`. At the k-th rising edge `ser_data` carries bit k, where bit 0 is the least significant bit.
- R5: `ser_data` never changes while `ser_clk` stays high.
- R6: Every high phase of `ser_clk` lasts `half_div`+1 system clocks, using the `half_div` value captured at start.
- R7: `s_ready` is high only in WAIT. It is low while `cfg_rst_n` is low, while a byte is partly shifted, and during the trailing clocks. Bytes offered early are held off until the reset interval has ended.
- R8: After the last byte, exactly TRAIL_CLKS (default 50) further rising edges of `ser_clk` occur, all with `ser_data`=0.
- R9: After the trailing clocks, `done` pulses for one cycle if both status inputs read 1. Otherwise `error` pulses for one cycle. The two never pulse together.
- R10: `tgt_status` holds {cfg_complete_in, tgt_stat_in}: bit 1 is the completion input and bit 0 is the status input, as sampled at the check.
- R11: `busy` is high from the cycle after start until the cycle in which `done` or `error` is high, and is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle load request, taken only in IDLE |
| half_div | input | DIV_W | Serial clock half period minus one, in system clocks |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Marks the final byte of the image |
| s_ready | output | 1 | Loader can accept a byte |
| pwr_off | output | 1 | Target power control, low = powered |
| cfg_rst_n | output | 1 | Target configuration reset, active low |
| ser_clk | output | 1 | Serial configuration clock |
| ser_data | output | 1 | Serial configuration data |
| cfg_complete_in | input | 1 | Target reports configuration complete (high = complete) |
| tgt_stat_in | input | 1 | Target status line (high = no fault) |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle pulse on successful load |
| error | output | 1 | One-cycle pulse on failed load |
| tgt_status | output | 2 | Sampled status pair, completion in bit 1 |

## Verification
The bench offers the first byte as soon as the load starts. A loader that opened the stream during the reset interval would therefore lose or misplace that byte in the captured bit stream. Random and directed images are rebuilt bit by bit from the serial edges and compared with an LSB-first expansion followed by the trailing zeros. A wrong bit order, a missing or extra trailing clock, or a data change while the clock is high shows up as a mismatch. All four status combinations are driven, so a loader that checked only one input, or swapped the bits of `tgt_status`, reports the wrong pulse or pair. Several `half_div` values, including zero, catch a divider that is off by one.

// File: rtl/pscfg_pkg.sv
package pscfg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RESET,
        ST_WAIT,
        ST_SHIFT,
        ST_TRAIL,
        ST_CHECK
    } cfg_state_e;
endpackage

// File: rtl/pscfg_clkgen.sv
module pscfg_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_len,
    output logic             sclk,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic [DIV_W-1:0] hcnt;
    logic             wrap;

    assign wrap      = run && (hcnt == half_len);
    assign rise_tick = wrap && !sclk;
    assign fall_tick = wrap && sclk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt <= '0;
            sclk <= 1'b0;
        end else if (!run) begin
            hcnt <= '0;
            sclk <= 1'b0;
        end else if (wrap) begin
            hcnt <= '0;
            sclk <= ~sclk;
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

    // R6: the clock sits low whenever the generator is stopped
    a_r6_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !sclk);
    // R6: a rise tick is followed by a high clock
    a_r6_rise_high: assert property (@(posedge clk) disable iff (!rst_n)
        rise_tick |=> sclk);
endmodule

// File: rtl/pscfg_shift.sv
module pscfg_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] din,
    input  logic       advance,
    output logic       sdata,
    output logic       last_bit
);
    logic [7:0] sreg;
    logic [2:0] bidx;

    assign sdata    = sreg[0];
    assign last_bit = (bidx == 3'd7);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
            bidx <= '0;
        end else if (load) begin
            sreg <= din;
            bidx <= '0;
        end else if (advance) begin
            sreg <= {1'b0, sreg[7:1]};
            bidx <= bidx + 1'b1;
        end
    end

    // R4: a load never coincides with a shift
    a_r4_load_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && advance));
endmodule

// File: rtl/pscfg_loader.sv
module pscfg_loader #(
    parameter int CLK_HZ     = 50_000_000,
    parameter int RESET_US   = 200,
    parameter int TRAIL_CLKS = 50,
    parameter int DIV_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DIV_W-1:0] half_div,
    input  logic             s_valid,
    input  logic [7:0]       s_data,
    input  logic             s_last,
    output logic             s_ready,
    output logic             pwr_off,
    output logic             cfg_rst_n,
    output logic             ser_clk,
    output logic             ser_data,
    input  logic             cfg_complete_in,
    input  logic             tgt_stat_in,
    output logic             busy,
    output logic             done,
    output logic             error,
    output logic [1:0]       tgt_status
);
    import pscfg_pkg::*;

    localparam int RST_CYC = (CLK_HZ / 1_000_000) * RESET_US;
    localparam int RCW     = $clog2(RST_CYC + 1);
    localparam int TCW     = $clog2(TRAIL_CLKS + 1);
    localparam logic [RCW-1:0] RST_LAST = RCW'(RST_CYC - 1);
    localparam logic [TCW-1:0] TRL_LAST = TCW'(TRAIL_CLKS - 1);

    cfg_state_e       state_q, state_d;
    logic [RCW-1:0]   rst_cnt;
    logic [TCW-1:0]   trl_cnt;
    logic [DIV_W-1:0] half_q;
    logic             last_q;
    logic [1:0]       sync1, sync2;
    logic             rise_tick, fall_tick, last_bit, accept, gen_run;

    assign accept  = (state_q == ST_WAIT) && s_valid;
    assign s_ready = (state_q == ST_WAIT);
    assign busy    = (state_q != ST_IDLE);
    assign gen_run = (state_q == ST_SHIFT) || (state_q == ST_TRAIL);

    pscfg_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (gen_run),
        .half_len  (half_q),
        .sclk      (ser_clk),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    pscfg_shift u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .din      (s_data),
        .advance  (fall_tick && (state_q == ST_SHIFT)),
        .sdata    (ser_data),
        .last_bit (last_bit)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_RESET;
            ST_RESET: if (rst_cnt == RST_LAST) state_d = ST_WAIT;
            ST_WAIT:  if (s_valid) state_d = ST_SHIFT;
            ST_SHIFT: if (fall_tick && last_bit) state_d = last_q ? ST_TRAIL : ST_WAIT;
            ST_TRAIL: if (fall_tick && (trl_cnt == TRL_LAST)) state_d = ST_CHECK;
            ST_CHECK: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs, counters and captured settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_cnt    <= '0;
            trl_cnt    <= '0;
            half_q     <= '0;
            last_q     <= 1'b0;
            pwr_off    <= 1'b1;
            cfg_rst_n  <= 1'b1;
            done       <= 1'b0;
            error      <= 1'b0;
            tgt_status <= 2'b00;
            sync1      <= 2'b00;
            sync2      <= 2'b00;
        end else begin
            sync1 <= {cfg_complete_in, tgt_stat_in};
            sync2 <= sync1;
            done  <= 1'b0;
            error <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    rst_cnt <= '0;
                    trl_cnt <= '0;
                    if (start) begin
                        half_q    <= half_div;
                        pwr_off   <= 1'b0;
                        cfg_rst_n <= 1'b0;
                    end
                end
                ST_RESET: begin
                    rst_cnt <= rst_cnt + 1'b1;
                    if (rst_cnt == RST_LAST) cfg_rst_n <= 1'b1;
                end
                ST_WAIT: begin
                    if (s_valid) last_q <= s_last;
                end
                ST_SHIFT: begin
                    trl_cnt <= '0;
                end
                ST_TRAIL: begin
                    if (fall_tick) trl_cnt <= trl_cnt + 1'b1;
                end
                ST_CHECK: begin
                    tgt_status <= sync2;
                    done       <= &sync2;
                    error      <= ~&sync2;
                end
                default: ;
            endcase
        end
    end

    // R2: the target stays powered throughout a load
    a_r2_power_on: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !pwr_off);
    // R3: configuration reset low exactly while counting the interval
    a_r3_reset_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESET) |-> !cfg_rst_n);
    // R3: released before bytes are taken
    a_r3_released: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> cfg_rst_n);
    // R5: data holds while the serial clock is high
    a_r5_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_data));
    // R7: a byte is taken only with the serial clock parked low
    a_r7_ready_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> !ser_clk);
    // R8: trailing clocks carry zero data
    a_r8_trail_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRAIL) |-> !ser_data);
    // R9: outcome pulses are exclusive and one cycle long
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r9_error_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> !error);
    // R11: busy has dropped when the outcome is reported
    a_r11_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) |-> !busy);
endmodule

// File: tb/tb_pscfg_loader.sv
module tb_pscfg_loader;
    localparam int CLK_PERIOD = 10;
    localparam int CLK_HZ     = 1_000_000;
    localparam int RESET_US   = 200;
    localparam int TRAIL      = 50;
    localparam int RST_CYC    = (CLK_HZ / 1_000_000) * RESET_US;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] half_div = '0;
    logic       s_valid = 1'b0;
    logic [7:0] s_data = '0;
    logic       s_last = 1'b0;
    logic       s_ready, pwr_off, cfg_rst_n, ser_clk, ser_data;
    logic       cfg_complete_in = 1'b0;
    logic       tgt_stat_in = 1'b0;
    logic       busy, done, error;
    logic [1:0] tgt_status;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pscfg_loader #(.CLK_HZ(CLK_HZ), .RESET_US(RESET_US), .TRAIL_CLKS(TRAIL), .DIV_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .half_div(half_div),
        .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
        .pwr_off(pwr_off), .cfg_rst_n(cfg_rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .cfg_complete_in(cfg_complete_in), .tgt_stat_in(tgt_stat_in),
        .busy(busy), .done(done), .error(error), .tgt_status(tgt_status)
    );

    // monitor state
    logic       cap[$];
    logic       prev_clk = 1'b0, prev_dat = 1'b0;
    int         hi_len = 0, exp_half = 1;
    int         hi_err = 0, stab_err = 0, rdy_err = 0, cfg_low = 0;
    bit         bytes_done = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (ser_clk && !prev_clk) cap.push_back(ser_data);
            if (ser_clk && prev_clk && (ser_data != prev_dat)) stab_err++;
            if (ser_clk) hi_len++;
            if (!ser_clk && prev_clk) begin
                if (hi_len != exp_half) hi_err++;
                hi_len = 0;
            end
            if (!cfg_rst_n) begin
                cfg_low++;
                if (s_ready) rdy_err++;
            end
            if (s_ready && ((cap.size() % 8) != 0)) rdy_err++;
            if (s_ready && bytes_done) rdy_err++;
        end
        prev_clk = ser_clk;
        prev_dat = ser_data;
    end

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_sim();
    end

    task automatic send_byte(input logic [7:0] b, input bit last);
        bit hs;
        repeat ($urandom_range(0, 3)) @(negedge clk);
        s_valid = 1'b1;
        s_data  = b;
        s_last  = last;
        forever begin
            hs = s_ready;
            @(posedge clk);
            if (hs) break;
            @(negedge clk);
        end
        @(negedge clk);
        s_valid = 1'b0;
        s_last  = 1'b0;
    endtask

    task automatic run_load(input int n, input int div, input bit cd, input bit st, input logic [7:0] first);
        logic [7:0] img[$];
        int         wait_cnt;
        int         bad;
        img.delete();
        img.push_back(first);
        for (int i = 1; i < n; i++) img.push_back(8'($urandom));
        half_div        = 8'(div);
        exp_half        = div + 1;
        cfg_complete_in = cd;
        tgt_stat_in     = st;
        @(negedge clk);
        cap.delete();
        hi_err = 0; stab_err = 0; rdy_err = 0; cfg_low = 0; hi_len = 0;
        bytes_done = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R11", "busy after start", int'(busy), 1);
        chk(pwr_off === 1'b0, "R2", "power on after start", int'(pwr_off), 0);
        for (int i = 0; i < n; i++) send_byte(img[i], i == n - 1);
        bytes_done = 1'b1;
        wait_cnt = 0;
        while (!(done || error) && wait_cnt < 20000) begin
            @(negedge clk);
            wait_cnt++;
            if (busy !== 1'b1 && !(done || error)) rdy_err++;
        end
        chk(busy === 1'b0, "R11", "busy low at outcome", int'(busy), 0);
        chk(done === (cd & st), "R9", "done", int'(done), int'(cd & st));
        chk(error === !(cd & st), "R9", "error", int'(error), int'(!(cd & st)));
        chk(tgt_status === {cd, st}, "R10", "status pair", int'(tgt_status), int'({cd, st}));
        chk(pwr_off === 1'b0, "R2", "power held", int'(pwr_off), 0);
        bytes_done = 1'b0;
        @(negedge clk);
        chk(!done && !error, "R9", "pulse width", int'({done, error}), 0);
        chk(cap.size() == 8 * n + TRAIL, "R8", "rising edge count", cap.size(), 8 * n + TRAIL);
        bad = 0;
        for (int k = 0; k < cap.size(); k++) begin
            logic e;
            e = (k < 8 * n) ? img[k / 8][k % 8] : 1'b0;
            if (cap[k] !== e) bad++;
        end
        chk(bad == 0, "R4", "LSB-first stream and R8 trailing zeros", bad, 0);
        chk(cfg_low == RST_CYC, "R3", "reset low cycles", cfg_low, RST_CYC);
        chk(stab_err == 0, "R5", "data moves while clock high", stab_err, 0);
        chk(hi_err == 0, "R6", "high phase length", hi_err, 0);
        chk(rdy_err == 0, "R7", "ready/busy outside allowed window", rdy_err, 0);
    endtask

    initial begin
        void'($urandom(32'h5eed_c0de));
        repeat (3) @(negedge clk);
        chk(pwr_off === 1'b1 && cfg_rst_n === 1'b1, "R1", "power/reset lines in reset", int'({pwr_off, cfg_rst_n}), 3);
        chk(ser_clk === 1'b0 && ser_data === 1'b0, "R1", "serial lines in reset", int'({ser_clk, ser_data}), 0);
        chk(busy === 1'b0 && s_ready === 1'b0 && done === 1'b0 && error === 1'b0,
            "R1", "status in reset", int'({busy, s_ready, done, error}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && pwr_off === 1'b1 && s_ready === 1'b0, "R1", "idle after reset",
            int'({busy, pwr_off, s_ready}), 2);
        // directed corners
        run_load(1, 0, 1'b1, 1'b1, 8'h01);
        run_load(2, 2, 1'b1, 1'b1, 8'h80);
        run_load(1, 1, 1'b0, 1'b1, 8'hA5);
        run_load(1, 0, 1'b1, 1'b0, 8'h5A);
        run_load(1, 3, 1'b0, 1'b0, 8'hFF);
        // random loads
        for (int t = 0; t < 10; t++) begin
            run_load($urandom_range(1, 6), $urandom_range(0, 3),
                     1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 3) != 0), 8'($urandom));
        end
        finish_sim();
    end
endmodule